// File: doc/BRIEF.md
# Low-Power Idle Receive Controller

This block is the receive-side sequencer for energy-efficient link idling. It follows the partner's low-power idle sequence using four inputs: the decoded block kind, the lane alignment status, the down-count value recovered from rapid alignment markers, and an energy-detect level. From these it moves between active, sleep, quiet, wake, wake-fault, link-fail and fast-wake states. Its outputs are an LPI-active flag, a receive mode, a qualified block-lock, a qualified align status and a saturating wake-error counter.

Three internal countdown timers bound the quiet, wake and wake-fault intervals. Their lengths are parameters. Rapid markers keep counting down while the partner wakes, so the controller gates its entry into sleep, its exit from sleep and its exit from wake on the down-count value. This keeps those transitions in step with the change between rapid and normal markers. In fast-wake operation no rapid markers are sent, and the block kind alone selects and leaves the fast-wake state.

All pins are plain control and status levels. The block carries no data stream, so it has no valid/ready handshake and no back-pressure. Every output is a register that updates on the clock edge after the inputs that cause the change.

Top module: `lpi_rx_ctrl`

## Requirements
- R1: While rst_n is low, lpi_active, rx_mode, blk_lock_out, align_out and wake_err_cnt are all 0. After reset the controller is in the active state.
- R2: In the active state, lpi_active is 0 and rx_mode is 0 (DATA). One cycle after each input value, blk_lock_out equals blk_lock_in and align_out equals align_ok.
- R3: From active with fast_wake_en low, the controller enters sleep only when all of these hold: align_ok is 1, blk_kind is 2 (LPI idle) and down_count is 255. lpi_active is then 1 on the next cycle. Any other combination leaves it active. Block kind codes are 0 data, 1 idle control, 2 LPI idle, 3 error.
- R4: From sleep, the controller enters quiet (rx_mode 1, QUIET) when align_ok drops while the quiet timer, started on sleep entry, is still running. While align_ok stays 1 it does not go quiet.
- R5: From sleep, align_ok 1, a blk_kind other than 2 and down_count 1 return the controller to active.
- R6: In quiet, energy_det moves the controller to wake (rx_mode 0, lpi_active kept at 1). With no energy, quiet-timer expiry (TQ_LEN cycles after sleep entry) enters link-fail for one cycle. Link-fail forces blk_lock_out to 0, and the controller then returns to active.
- R7: From wake, align_ok 1 with blk_kind 1 and down_count 1 goes to active. align_ok 1 with blk_kind 2 and down_count 255 re-enters sleep and restarts the quiet timer.
- R8: If the controller stays in wake for TW_LEN cycles, it enters wake-fault, which increments wake_err_cnt once, saturating at all ones. After TWF_LEN cycles in wake-fault it returns to active.
- R9: With fast_wake_en high, blk_kind 2 in active enters fast-wake (lpi_active 1, rx_mode 0) for any down_count or align_ok. Fast-wake never goes quiet. Any blk_kind other than 2 returns it to active.
- R10: From sleep, align_ok 1 with blk_kind 2 and down_count below 255 enters wake. In wake, a loss of alignment does not lead to quiet.
- R11: If align_ok drops in sleep after the quiet timer has already expired, the controller enters link-fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_wake_en | input | 1 | Selects fast-wake operation (no rapid markers) |
| blk_kind | input | 2 | Decoded block kind: 0 data, 1 idle control, 2 LPI idle, 3 error |
| align_ok | input | 1 | Lane alignment status from the marker lock logic |
| blk_lock_in | input | 1 | Block lock from the block synchronizer |
| down_count | input | 8 | Down-count recovered from the current rapid marker |
| energy_det | input | 1 | Line energy detected |
| lpi_active | output | 1 | Receive LPI active flag |
| rx_mode | output | 1 | Receive mode: 0 DATA, 1 QUIET |
| blk_lock_out | output | 1 | Qualified block lock |
| align_out | output | 1 | Qualified alignment status |
| wake_err_cnt | output | CNT_W | Saturating count of wake faults |

## Verification
The bench sweeps block kind, down-count, alignment and fast-wake against the entry into sleep. A design that checked the block kind alone would sleep on the wrong marker, or would ignore the fast-wake selection. It also sweeps every sleep exit and tells sleep and wake apart by then dropping alignment. A controller that confused the two would go quiet out of wake, or stay in sleep when the partner is waking. It re-enters sleep late in a wake so that a quiet timer that fails to restart shows up as a false link-fail. The quiet, wake and wake-fault timers are counted to the exact cycle, and the wake-error counter is driven past its saturation point.

// File: rtl/lpi_rx_pkg.sv
package lpi_rx_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_QUIET  = 3'd2,
    ST_WAKE   = 3'd3,
    ST_WFAULT = 3'd4,
    ST_LFAIL  = 3'd5,
    ST_FASTW  = 3'd6
  } lpi_state_e;

  localparam logic [1:0] BK_DATA = 2'd0;
  localparam logic [1:0] BK_IDLE = 2'd1;
  localparam logic [1:0] BK_LPI  = 2'd2;
  localparam logic [1:0] BK_ERR  = 2'd3;

  localparam logic [7:0] DC_SLEEP = 8'd255;
  localparam logic [7:0] DC_LAST  = 8'd1;

  localparam int unsigned N_TMR = 3;
  localparam int unsigned T_QUIET = 0;
  localparam int unsigned T_WAKE  = 1;
  localparam int unsigned T_WFLT  = 2;
endpackage

// File: rtl/lpi_rx_timer.sv
module lpi_rx_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic done
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt;
  logic          run;

  // Load with LEN-1 and count down; done is the single cycle at zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= CW'(LEN - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign running = run;
  assign done    = run && (cnt == '0);
endmodule

// File: rtl/lpi_rx_fsm.sv
module lpi_rx_fsm
  import lpi_rx_pkg::*;
(
  input  lpi_state_e cur,
  input  logic       fw_en,
  input  logic       align_ok,
  input  logic [1:0] bkind,
  input  logic [7:0] dcount,
  input  logic       energy,
  input  logic       tq_run,
  input  logic       tq_done,
  input  logic       tw_done,
  input  logic       wf_done,
  output lpi_state_e nxt
);
  logic is_lpi, last_mark, sleep_mark;

  assign is_lpi     = (bkind == BK_LPI);
  assign last_mark  = (dcount == DC_LAST);
  assign sleep_mark = (dcount == DC_SLEEP);

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_ACTIVE: begin
        if (fw_en && is_lpi)                             nxt = ST_FASTW;
        else if (!fw_en && align_ok && is_lpi && sleep_mark) nxt = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!align_ok && tq_run && !tq_done)             nxt = ST_QUIET;
        else if (!align_ok)                              nxt = ST_LFAIL;
        else if (!is_lpi && last_mark)                   nxt = ST_ACTIVE;
        else if (is_lpi && !sleep_mark)                  nxt = ST_WAKE;
      end
      ST_QUIET: begin
        if (energy)       nxt = ST_WAKE;
        else if (tq_done) nxt = ST_LFAIL;
      end
      ST_WAKE: begin
        if (align_ok && bkind == BK_IDLE && last_mark)   nxt = ST_ACTIVE;
        else if (align_ok && is_lpi && sleep_mark)       nxt = ST_SLEEP;
        else if (tw_done)                                nxt = ST_WFAULT;
      end
      ST_WFAULT: if (wf_done) nxt = ST_ACTIVE;
      ST_LFAIL:  nxt = ST_ACTIVE;
      ST_FASTW:  if (!is_lpi) nxt = ST_ACTIVE;
      default:   nxt = ST_ACTIVE;
    endcase
  end
endmodule

// File: rtl/lpi_rx_ctrl.sv
module lpi_rx_ctrl
  import lpi_rx_pkg::*;
#(
  parameter int unsigned TQ_LEN  = 64,
  parameter int unsigned TW_LEN  = 16,
  parameter int unsigned TWF_LEN = 24,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_wake_en,
  input  logic [1:0]       blk_kind,
  input  logic             align_ok,
  input  logic             blk_lock_in,
  input  logic [7:0]       down_count,
  input  logic             energy_det,
  output logic             lpi_active,
  output logic             rx_mode,
  output logic             blk_lock_out,
  output logic             align_out,
  output logic [CNT_W-1:0] wake_err_cnt
);
  function automatic int unsigned tmr_len(int unsigned idx);
    case (idx)
      T_QUIET: return TQ_LEN;
      T_WAKE:  return TW_LEN;
      default: return TWF_LEN;
    endcase
  endfunction

  function automatic lpi_state_e tmr_state(int unsigned idx);
    case (idx)
      T_QUIET: return ST_SLEEP;
      T_WAKE:  return ST_WAKE;
      default: return ST_WFAULT;
    endcase
  endfunction

  lpi_state_e st_q, st_d;
  logic [N_TMR-1:0] t_start, t_run, t_done;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    assign t_start[g] = (st_d == tmr_state(g)) && (st_q != tmr_state(g));
    lpi_rx_timer #(.LEN(tmr_len(g))) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (t_start[g]),
      .running (t_run[g]),
      .done    (t_done[g])
    );
  end

  lpi_rx_fsm u_fsm (
    .cur      (st_q),
    .fw_en    (fast_wake_en),
    .align_ok (align_ok),
    .bkind    (blk_kind),
    .dcount   (down_count),
    .energy   (energy_det),
    .tq_run   (t_run[T_QUIET]),
    .tq_done  (t_done[T_QUIET]),
    .tw_done  (t_done[T_WAKE]),
    .wf_done  (t_done[T_WFLT]),
    .nxt      (st_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_ACTIVE;
    else        st_q <= st_d;
  end

  // Outputs are variables set by the state being entered; others hold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpi_active   <= 1'b0;
      rx_mode      <= 1'b0;
      blk_lock_out <= 1'b0;
      align_out    <= 1'b0;
    end else begin
      unique case (st_d)
        ST_ACTIVE: begin
          lpi_active   <= 1'b0;
          rx_mode      <= 1'b0;
          blk_lock_out <= blk_lock_in;
          align_out    <= align_ok;
        end
        ST_SLEEP, ST_FASTW: lpi_active <= 1'b1;
        ST_QUIET:           rx_mode    <= 1'b1;
        ST_WAKE:            rx_mode    <= 1'b0;
        ST_LFAIL:           blk_lock_out <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wake_err_cnt <= '0;
    else if (t_start[T_WFLT] && (wake_err_cnt != '1))
      wake_err_cnt <= wake_err_cnt + 1'b1;
  end
endmodule

// File: rtl/lpi_rx_ctrl_chk.sv
module lpi_rx_ctrl_chk
  import lpi_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input lpi_state_e       st,
  input logic             lpi_active,
  input logic             rx_mode,
  input logic             blk_lock_out,
  input logic             align_out,
  input logic             blk_lock_in,
  input logic             align_ok,
  input logic [CNT_W-1:0] wake_err_cnt
);
  a_r2_active_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && $past(rst_n)) |->
      (blk_lock_out == $past(blk_lock_in) && align_out == $past(align_ok)
       && !lpi_active && !rx_mode));

  a_r3_sleep_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP) |-> lpi_active);

  a_r4_quiet_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_QUIET) |-> (rx_mode && lpi_active));

  a_r4_quiet_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && st == ST_QUIET && $past(st) == ST_SLEEP) |-> !$past(align_ok));

  a_r6_fail_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LFAIL) |-> !blk_lock_out);

  a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && wake_err_cnt != $past(wake_err_cnt)) |->
      (st == ST_WFAULT && wake_err_cnt == $past(wake_err_cnt) + CNT_W'(1)));

  a_r9_fast_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FASTW) |-> (lpi_active && !rx_mode));
endmodule

bind lpi_rx_ctrl lpi_rx_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .st           (st_q),
  .lpi_active   (lpi_active),
  .rx_mode      (rx_mode),
  .blk_lock_out (blk_lock_out),
  .align_out    (align_out),
  .blk_lock_in  (blk_lock_in),
  .align_ok     (align_ok),
  .wake_err_cnt (wake_err_cnt)
);

// File: tb/lpi_rx_ctrl_test.sv
module lpi_rx_ctrl_test;
  localparam int TQ = 8;
  localparam int TW = 6;
  localparam int TWF = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fw = 1'b0;
  logic [1:0] bk = 2'd0;
  logic al = 1'b0;
  logic bl = 1'b0;
  logic [7:0] dc = 8'd0;
  logic en = 1'b0;
  logic lpi, mode, lock_o, al_o;
  logic [CW-1:0] cnt;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lpi_rx_ctrl #(.TQ_LEN(TQ), .TW_LEN(TW), .TWF_LEN(TWF), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .fast_wake_en(fw), .blk_kind(bk),
    .align_ok(al), .blk_lock_in(bl), .down_count(dc), .energy_det(en),
    .lpi_active(lpi), .rx_mode(mode), .blk_lock_out(lock_o),
    .align_out(al_o), .wake_err_cnt(cnt)
  );

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(bit f, logic [1:0] k, bit a, int d, bit e, bit b);
    fw = f; bk = k; al = a; dc = 8'(d); en = e; bl = b;
  endtask

  task automatic go_active();
    drive(0, 2'd1, 1, 1, 0, 1);
    step();
  endtask

  task automatic to_sleep();
    drive(0, 2'd2, 1, 255, 0, 1);
    step();
  endtask

  task automatic to_quiet();
    drive(0, 2'd0, 0, 0, 0, 1);
    step();
  endtask

  task automatic to_wake_from_quiet();
    drive(0, 2'd0, 0, 0, 1, 1);
    step();
    en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int dcs[6] = '{0, 1, 2, 54, 254, 255};
    // R1 reset
    repeat (3) step();
    check("R1 lpi", lpi, 0);
    check("R1 mode", mode, 0);
    check("R1 lock", lock_o, 0);
    check("R1 align", al_o, 0);
    check("R1 cnt", cnt, 0);
    rst_n = 1'b1;
    step();

    // R2 pass-through in active
    for (int i = 0; i < 4; i++) begin
      drive(0, 2'd0, i[0], 0, 0, i[1]);
      step();
      check("R2 lock", lock_o, i[1]);
      check("R2 align", al_o, i[0]);
      check("R2 lpi", lpi, 0);
      check("R2 mode", mode, 0);
    end

    // R3 / R9 sweep of the entry into low-power states
    for (int f = 0; f < 2; f++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 2; a++)
          for (int j = 0; j < 6; j++) begin
            int e;
            drive(f[0], 2'(k), a[0], dcs[j], 0, 1);
            step();
            if (f == 1) e = (k == 2) ? 1 : 0;
            else e = (a == 1 && k == 2 && dcs[j] == 255) ? 1 : 0;
            check(f == 1 ? "R9 enter" : "R3 enter", lpi, e);
            check("R3 mode", mode, 0);
            go_active();
            check("R5 back", lpi, 0);
          end

    // R5 / R10 sweep of sleep exits
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 6; j++) begin
        bit is_act, is_wake;
        is_act  = (k != 2 && dcs[j] == 1);
        is_wake = (k == 2 && dcs[j] < 255);
        to_sleep();
        check("R3 sleep", lpi, 1);
        drive(0, 2'(k), 1, dcs[j], 0, 1);
        step();
        check(is_act ? "R5 exit" : "R10 exit", lpi, is_act ? 0 : 1);
        if (!is_act) begin
          to_quiet();
          check(is_wake ? "R10 no quiet" : "R4 quiet", mode, is_wake ? 0 : 1);
          if (!is_wake) begin
            to_wake_from_quiet();
            check("R6 wake mode", mode, 0);
            check("R6 wake lpi", lpi, 1);
          end
          go_active();
          check("R7 active", lpi, 0);
        end
      end

    // R6 quiet timer expiry to link fail
    go_active();
    to_sleep();
    to_quiet();
    check("R4 quiet", mode, 1);
    for (int i = 0; i < TQ - 2; i++) begin
      step();
      check("R6 still quiet", mode, 1);
      check("R6 lock held", lock_o, 1);
    end
    step();
    check("R6 link fail lock", lock_o, 0);
    step();
    check("R6 relock", lock_o, 1);
    check("R6 mode data", mode, 0);
    check("R6 lpi off", lpi, 0);

    // R11 alignment loss after quiet window expired
    to_sleep();
    for (int i = 0; i < TQ + 1; i++) begin
      step();
      check("R4 stay sleep", mode, 0);
    end
    to_quiet();
    check("R11 fail lock", lock_o, 0);
    check("R11 mode", mode, 0);
    step();
    check("R11 back", lpi, 0);

    // R7 late re-entry into sleep restarts the quiet timer
    go_active();
    to_sleep();
    to_quiet();
    to_wake_from_quiet();
    drive(0, 2'd0, 0, 0, 0, 1);
    repeat (TW - 2) step();
    to_sleep();
    to_quiet();
    check("R7 restart quiet", mode, 1);
    check("R7 lock", lock_o, 1);
    to_wake_from_quiet();
    go_active();
    check("R7 active", lpi, 0);

    // R8 wake fault timing and saturation
    for (int r = 0; r < 4; r++) begin
      to_sleep();
      to_quiet();
      to_wake_from_quiet();
      drive(0, 2'd0, 0, 0, 0, 1);
      for (int i = 0; i < TW - 1; i++) begin
        step();
        check("R8 cnt hold", cnt, exp_cnt);
      end
      step();
      if (exp_cnt < 3) exp_cnt++;
      check("R8 cnt step", cnt, exp_cnt);
      for (int i = 0; i < TWF - 1; i++) begin
        step();
        check("R8 fault lpi", lpi, 1);
      end
      step();
      check("R8 fault exit", lpi, 0);
    end

    // R9 fast-wake never goes quiet
    drive(1, 2'd2, 1, 17, 0, 1);
    step();
    check("R9 lpi", lpi, 1);
    drive(1, 2'd2, 0, 0, 0, 1);
    for (int i = 0; i < TQ + 2; i++) begin
      step();
      check("R9 no quiet", mode, 0);
      check("R9 held", lpi, 1);
    end
    drive(1, 2'd3, 1, 255, 0, 1);
    step();
    check("R9 leave", lpi, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule